// File: doc/BRIEF.md
# Endpoint Configuration Register File and Buffer Allocator

This block keeps one 8-bit configuration byte for each of sixteen device endpoints (control OUT, control IN, then endpoints 1 to 14) and turns those bytes into a map of a shared 16-bit-wide buffer RAM. A host processor reaches the bytes through one-word commands on a 16-bit command/data port. A write command carries the new byte in the low half of the data word. A read command returns the stored byte in the low half of `rd_data`.

The map is built only when the sixteen bytes have been written as one pass in index order. The last write of the pass starts a sequencer. The sequencer visits one endpoint per clock and places each enabled endpoint directly after the previous one. The result is a word base address, a word length and an active flag for every endpoint. A USB bus reset disables all endpoints and drops the map. Once a map exists, a later change that alters the buffer space of an endpoint raises a sticky flag saying that the buffer contents are no longer trustworthy.

Top module: `ep_cfg_alloc`

## Requirements
- R1: After reset, all sixteen configuration bytes are zero, no endpoint is active, every base and length output is zero, and `alloc_done`, `alloc_overflow` and `fifo_invalid` are low.
- R2: A write command with code 0x20+i (i = 0..15) stores `wr_data[7:0]` into byte i. A read command with code 0x30+i shows byte i on `rd_data[7:0]` in the cycle after the command. The byte fields are: bit 7 enable, bit 6 direction (1 = IN), bit 5 double buffering, bit 4 isochronous, bits 3:0 size code.
- R3: A command with a code outside 0x20..0x3F changes no configuration byte.
- R4: Allocation starts only when the bytes have been written in the order 0,1,...,15 with no other write in between. A write out of order restarts the count: a write to byte 0 counts as the first of a new pass, and a write to any other byte leaves the count at zero.
- R5: Allocation walks the endpoints from index 0 to 15. An enabled endpoint reserves 4<<code words, which is (N+1) div 2 words for N = 8<<code bytes. Double buffering doubles this amount. Each placed endpoint gets the next free word address as its base, starting at 0. A disabled endpoint has active = 0, base = 0 and length = 0.
- R6: `alloc_done` is a one-cycle pulse that rises on the 17th clock edge after the edge that samples the final write of a pass.
- R7: An enabled endpoint whose reservation would push the total past `RAM_WORDS` is left inactive and sets `alloc_overflow`. Later endpoints that still fit are placed. An active endpoint always ends at or below `RAM_WORDS`.
- R8: A write command that arrives while allocation is pending or running leaves the configuration bytes unchanged.
- R9: While `bus_reset` is high, the enable bit of every byte is cleared on the next edge. The other bits keep their values. The same edge aborts any allocation in progress, clears all active, base and length outputs, and restarts the write count.
- R10: After an allocation has completed, `fifo_invalid` is set by either of two events. The first is a write that changes the enable, double-buffer or size field of an endpoint that is enabled before or after the write. The second is a bus reset while any endpoint is enabled. Changes to only the direction or isochronous bits do not set it. The flag clears when the next allocation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command code |
| wr_data | input | 16 | Write data word; the low byte is used |
| rd_data | output | 16 | Read data word; the low byte is the register and the upper byte is zero |
| bus_reset | input | 1 | USB bus reset indication |
| ep_active | output | 16 | Endpoint has buffer space mapped |
| ep_base | output | 160 | Word base address per endpoint, 10 bits each, endpoint i at [10i +: 10] |
| ep_len | output | 176 | Word length per endpoint, 11 bits each, endpoint i at [11i +: 11] |
| alloc_done | output | 1 | One-cycle pulse when a map is complete |
| alloc_overflow | output | 1 | At least one enabled endpoint could not be placed |
| fifo_invalid | output | 1 | Sticky flag: buffer contents are no longer valid |

## Verification
The allocator is driven with many randomly generated configuration passes from a fixed seed. Small size codes produce maps that fit, and occasional large codes produce overflow. Each case shows whether the bases are contiguous, whether disabled endpoints are skipped, and whether double buffering is applied.

Directed passes test four further cases. The first is an exact fit at the capacity limit. The second is an interrupted write sequence and a restart from byte 0, which tells a real pass apart from a partial one. The third is writes and bus resets during allocation. The fourth is a set of edits that differ only in direction or type bits compared with edits to size or enable, which separates a harmless change from one that invalidates the buffers.

// File: rtl/epcfg_pkg.sv
package epcfg_pkg;

    typedef struct packed {
        logic       en;
        logic       dir_in;
        logic       dbl;
        logic       iso;
        logic [3:0] size;
    } ep_cfg_t;

    localparam int NEED_W = 24;

    // 16-bit words needed to hold n bytes
    function automatic logic [NEED_W-1:0] bytes_to_words(input logic [NEED_W-1:0] n);
        return (n + NEED_W'(1)) >> 1;
    endfunction

    // words reserved by one endpoint (ignores its enable bit)
    function automatic logic [NEED_W-1:0] reserve_words(input ep_cfg_t c);
        logic [NEED_W-1:0] nbytes;
        logic [NEED_W-1:0] w;
        nbytes = NEED_W'(8) << c.size;
        w      = bytes_to_words(nbytes);
        return c.dbl ? (w << 1) : w;
    endfunction

endpackage

// File: rtl/epcfg_cmd_dec.sv
module epcfg_cmd_dec #(
    parameter int         NUM_EP  = 16,
    parameter logic [7:0] WR_BASE = 8'h20,
    parameter logic [7:0] RD_BASE = 8'h30,
    localparam int        IDX_W   = $clog2(NUM_EP)
) (
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    output logic             wr_hit,
    output logic             rd_hit,
    output logic [IDX_W-1:0] idx
);
    logic [8:0] wr_off;
    logic [8:0] rd_off;

    always_comb begin
        wr_off = {1'b0, cmd_code} - {1'b0, WR_BASE};
        rd_off = {1'b0, cmd_code} - {1'b0, RD_BASE};
        wr_hit = cmd_valid && (cmd_code >= WR_BASE) && (wr_off < 9'(NUM_EP));
        rd_hit = cmd_valid && (cmd_code >= RD_BASE) && (rd_off < 9'(NUM_EP));
        idx    = rd_hit ? rd_off[IDX_W-1:0] : wr_off[IDX_W-1:0];
    end
endmodule

// File: rtl/epcfg_regs.sv
module epcfg_regs
    import epcfg_pkg::*;
#(
    parameter int  NUM_EP = 16,
    localparam int IDX_W  = $clog2(NUM_EP)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_hit,
    input  logic                    rd_hit,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              wr_byte,
    input  logic                    bus_reset,
    input  logic                    busy,
    input  logic                    alloc_last,
    output ep_cfg_t [NUM_EP-1:0]    cfg_o,
    output logic                    start_o,
    output logic                    inv_o,
    output logic [7:0]              rd_byte_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_EP - 1);

    typedef struct packed {
        ep_cfg_t [NUM_EP-1:0] cfg;
        logic [IDX_W-1:0]     seq;
        logic                 start;
        logic                 mapped;
        logic                 inv;
        logic [7:0]           rd;
    } regs_st_t;

    regs_st_t st_q, st_d;
    ep_cfg_t  old_c, new_c;
    logic [NUM_EP-1:0] en_vec;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        old_c      = st_q.cfg[idx];
        new_c      = ep_cfg_t'(wr_byte);
        for (int i = 0; i < NUM_EP; i++) en_vec[i] = st_q.cfg[i].en;

        if (alloc_last) begin
            st_d.mapped = 1'b1;
            st_d.inv    = 1'b0;
        end
        if (rd_hit) st_d.rd = st_q.cfg[idx];

        if (bus_reset) begin
            for (int i = 0; i < NUM_EP; i++) st_d.cfg[i].en = 1'b0;
            st_d.seq = '0;
            if (st_q.mapped && (|en_vec)) st_d.inv = 1'b1;
            st_d.mapped = 1'b0;
        end else if (wr_hit && !busy && !st_q.start) begin
            st_d.cfg[idx] = new_c;
            if (st_q.mapped && (old_c.en || new_c.en) &&
                ({old_c.en, old_c.dbl, old_c.size} != {new_c.en, new_c.dbl, new_c.size}))
                st_d.inv = 1'b1;
            if (idx == st_q.seq) begin
                if (idx == LAST) begin
                    st_d.start = 1'b1;
                    st_d.seq   = '0;
                end else begin
                    st_d.seq = st_q.seq + 1'b1;
                end
            end else begin
                st_d.seq = (idx == '0) ? IDX_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o     = st_q.cfg;
    assign start_o   = st_q.start;
    assign inv_o     = st_q.inv;
    assign rd_byte_o = st_q.rd;

    // R8: writes while the allocator is pending or running leave the bytes alone
    assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (busy || start_o) && !bus_reset) |=> $stable(cfg_o));

    // R9: bus reset drops every enable bit
    assert_bus_reset_clears_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (en_vec == '0));
endmodule

// File: rtl/epcfg_alloc.sv
module epcfg_alloc
    import epcfg_pkg::*;
#(
    parameter int  NUM_EP    = 16,
    parameter int  RAM_WORDS = 1024,
    localparam int IDX_W     = $clog2(NUM_EP),
    localparam int ADDR_W    = $clog2(RAM_WORDS),
    localparam int LEN_W     = ADDR_W + 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic                               bus_reset,
    input  ep_cfg_t [NUM_EP-1:0]               cfg_i,
    output logic                               busy_o,
    output logic                               last_o,
    output logic                               done_o,
    output logic                               ovf_o,
    output logic [NUM_EP-1:0]                  act_o,
    output logic [NUM_EP-1:0][ADDR_W-1:0]      base_o,
    output logic [NUM_EP-1:0][LEN_W-1:0]       len_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_EP - 1);
    localparam logic [NEED_W:0]  CAP  = (NEED_W+1)'(RAM_WORDS);

    typedef struct packed {
        logic                          busy;
        logic [IDX_W-1:0]              idx;
        logic [LEN_W-1:0]              acc;
        logic                          ovf;
        logic                          done;
        logic [NUM_EP-1:0]             act;
        logic [NUM_EP-1:0][ADDR_W-1:0] base;
        logic [NUM_EP-1:0][LEN_W-1:0]  len;
    } alloc_st_t;

    alloc_st_t         st_q, st_d;
    ep_cfg_t           cur;
    logic [NEED_W-1:0] need;
    logic [NEED_W:0]   sum;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cur       = cfg_i[st_q.idx];
        need      = reserve_words(cur);
        sum       = {1'b0, need} + (NEED_W+1)'(st_q.acc);

        if (bus_reset) begin
            st_d = '0;
        end else if (start) begin
            st_d      = '0;
            st_d.busy = 1'b1;
        end else if (st_q.busy) begin
            if (cur.en) begin
                if (sum <= CAP) begin
                    st_d.act[st_q.idx]  = 1'b1;
                    st_d.base[st_q.idx] = st_q.acc[ADDR_W-1:0];
                    st_d.len[st_q.idx]  = need[LEN_W-1:0];
                    st_d.acc            = sum[LEN_W-1:0];
                end else begin
                    st_d.ovf = 1'b1;
                end
            end
            if (st_q.idx == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign last_o = st_q.busy && (st_q.idx == LAST) && !bus_reset;
    assign done_o = st_q.done;
    assign ovf_o  = st_q.ovf;
    assign act_o  = st_q.act;
    assign base_o = st_q.base;
    assign len_o  = st_q.len;

    // R6: completion is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_chk
        // R7: a placed endpoint lies inside the buffer RAM
        assert_fits_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
            act_o[g] |-> ((LEN_W+1)'(base_o[g]) + (LEN_W+1)'(len_o[g]) <= (LEN_W+1)'(RAM_WORDS)));
        // R5: an unplaced endpoint reports no space
        assert_idle_len_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !act_o[g] |-> (len_o[g] == '0 && base_o[g] == '0));
    end
endmodule

// File: rtl/ep_cfg_alloc.sv
module ep_cfg_alloc
    import epcfg_pkg::*;
#(
    parameter int         NUM_EP    = 16,
    parameter int         RAM_WORDS = 1024,
    parameter logic [7:0] WR_BASE   = 8'h20,
    parameter logic [7:0] RD_BASE   = 8'h30,
    localparam int        ADDR_W    = $clog2(RAM_WORDS),
    localparam int        LEN_W     = ADDR_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [7:0]                 cmd_code,
    input  logic [15:0]                wr_data,
    output logic [15:0]                rd_data,
    input  logic                       bus_reset,
    output logic [NUM_EP-1:0]          ep_active,
    output logic [NUM_EP*ADDR_W-1:0]   ep_base,
    output logic [NUM_EP*LEN_W-1:0]    ep_len,
    output logic                       alloc_done,
    output logic                       alloc_overflow,
    output logic                       fifo_invalid
);
    localparam int IDX_W = $clog2(NUM_EP);

    logic                          wr_hit, rd_hit;
    logic [IDX_W-1:0]              idx;
    ep_cfg_t [NUM_EP-1:0]          cfg;
    logic                          start, busy, last;
    logic [7:0]                    rd_byte;
    logic [NUM_EP-1:0][ADDR_W-1:0] base;
    logic [NUM_EP-1:0][LEN_W-1:0]  len;

    epcfg_cmd_dec #(.NUM_EP(NUM_EP), .WR_BASE(WR_BASE), .RD_BASE(RD_BASE)) dec_i (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit),
        .idx       (idx)
    );

    epcfg_regs #(.NUM_EP(NUM_EP)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .rd_hit     (rd_hit),
        .idx        (idx),
        .wr_byte    (wr_data[7:0]),
        .bus_reset  (bus_reset),
        .busy       (busy),
        .alloc_last (last),
        .cfg_o      (cfg),
        .start_o    (start),
        .inv_o      (fifo_invalid),
        .rd_byte_o  (rd_byte)
    );

    epcfg_alloc #(.NUM_EP(NUM_EP), .RAM_WORDS(RAM_WORDS)) alloc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bus_reset (bus_reset),
        .cfg_i     (cfg),
        .busy_o    (busy),
        .last_o    (last),
        .done_o    (alloc_done),
        .ovf_o     (alloc_overflow),
        .act_o     (ep_active),
        .base_o    (base),
        .len_o     (len)
    );

    assign rd_data = {8'h00, rd_byte};

    for (genvar g = 0; g < NUM_EP; g++) begin : g_flat
        assign ep_base[g*ADDR_W +: ADDR_W] = base[g];
        assign ep_len[g*LEN_W +: LEN_W]    = len[g];
    end

    // R10: a freshly completed map is never reported as invalid
    assert_invalid_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_done |-> !fifo_invalid);
endmodule

// File: tb/ep_cfg_alloc_tb_top.sv
`timescale 1ns/1ps
module ep_cfg_alloc_tb_top;
    localparam int NUM_EP = 16;
    localparam int RAM_WORDS = 1024;
    localparam int ADDR_W = 10;
    localparam int LEN_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic bus_reset = 1'b0;
    logic [NUM_EP-1:0] ep_active;
    logic [NUM_EP*ADDR_W-1:0] ep_base;
    logic [NUM_EP*LEN_W-1:0] ep_len;
    logic alloc_done, alloc_overflow, fifo_invalid;

    int checks = 0;
    int errors = 0;
    logic [7:0] cfgb [NUM_EP];
    int exp_act [NUM_EP];
    int exp_base [NUM_EP];
    int exp_len [NUM_EP];
    int exp_ovf;

    always #2.5 clk = ~clk;

    ep_cfg_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wr_data(wr_data), .rd_data(rd_data), .bus_reset(bus_reset),
        .ep_active(ep_active), .ep_base(ep_base), .ep_len(ep_len),
        .alloc_done(alloc_done), .alloc_overflow(alloc_overflow), .fifo_invalid(fifo_invalid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] code, input logic [15:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; wr_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd_reg(input int i, output int v);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'h30 + 8'(i);
        @(negedge clk);
        cmd_valid = 1'b0;
        v = int'(rd_data[7:0]);
    endtask

    task automatic write_all();
        for (int i = 0; i < NUM_EP; i++) cmd(8'h20 + 8'(i), {8'hA5, cfgb[i]});
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!alloc_done && n < 60) begin
            @(negedge clk);
            n++;
        end
        if (!alloc_done) n = -1;
    endtask

    task automatic model();
        int acc = 0;
        exp_ovf = 0;
        for (int i = 0; i < NUM_EP; i++) begin
            int need;
            exp_act[i] = 0; exp_base[i] = 0; exp_len[i] = 0;
            need = (4 << cfgb[i][3:0]) * (cfgb[i][5] ? 2 : 1);
            if (cfgb[i][7]) begin
                if (acc + need <= RAM_WORDS) begin
                    exp_act[i] = 1; exp_base[i] = acc; exp_len[i] = need; acc += need;
                end else exp_ovf = 1;
            end
        end
    endtask

    task automatic check_map(input string tag);
        model();
        chk({tag, " R7 overflow"}, int'(alloc_overflow), exp_ovf);
        for (int i = 0; i < NUM_EP; i++) begin
            chk({tag, " R5 active"}, int'(ep_active[i]), exp_act[i]);
            chk({tag, " R5 base"}, int'(ep_base[i*ADDR_W +: ADDR_W]), exp_base[i]);
            chk({tag, " R5 len"}, int'(ep_len[i*LEN_W +: LEN_W]), exp_len[i]);
        end
    endtask

    task automatic full_pass(input string tag);
        int n;
        write_all();
        wait_done(n);
        chk({tag, " R6 done latency"}, n, 17);
        check_map(tag);
        chk({tag, " R10 invalid cleared"}, int'(fifo_invalid), 0);
        @(negedge clk);
        chk({tag, " R6 done one cycle"}, int'(alloc_done), 0);
    endtask

    task automatic pulse_bus_reset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 active", int'(ep_active), 0);
        chk("R1 base", int'(|ep_base), 0);
        chk("R1 len", int'(|ep_len), 0);
        chk("R1 done", int'(alloc_done), 0);
        chk("R1 overflow", int'(alloc_overflow), 0);
        chk("R1 invalid", int'(fifo_invalid), 0);
        for (int i = 0; i < NUM_EP; i++) begin rd_reg(i, v); chk("R1 reg zero", v, 0); end

        // R3 foreign codes
        cmd(8'h40, 16'h00FF); cmd(8'h1F, 16'h00FF); cmd(8'h10, 16'h00FF);
        rd_reg(0, v); chk("R3 reg0 untouched", v, 0);
        rd_reg(15, v); chk("R3 reg15 untouched", v, 0);

        // R2 write/readback
        cmd(8'h27, 16'hFF6B); rd_reg(7, v); chk("R2 readback", v, 8'h6B);
        chk("R2 upper byte", int'(rd_data[15:8]), 0);

        // R4 interrupted pass: no allocation
        for (int i = 0; i < NUM_EP; i++) cfgb[i] = 8'h80 | 8'(i % 3);
        for (int i = 0; i < 8; i++) cmd(8'h20 + 8'(i), {8'h00, cfgb[i]});
        cmd(8'h23, {8'h00, cfgb[3]});
        for (int i = 8; i < NUM_EP; i++) cmd(8'h20 + 8'(i), {8'h00, cfgb[i]});
        wait_done(n); chk("R4 no alloc after gap", n, -1);
        // R4 restart at byte 0 counts as first write
        for (int i = 0; i < 6; i++) cmd(8'h20 + 8'(i), {8'h00, cfgb[i]});
        for (int i = 0; i < NUM_EP; i++) cmd(8'h20 + 8'(i), {8'h00, cfgb[i]});
        wait_done(n); chk("R4 alloc after restart", n, 17);
        check_map("R4");

        // random passes
        for (int p = 0; p < 30; p++) begin
            for (int i = 0; i < NUM_EP; i++) begin
                logic [3:0] code;
                code = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 5);
                cfgb[i] = {1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), code};
            end
            full_pass("rand");
            for (int k = 0; k < 2; k++) begin
                int i = int'($urandom % NUM_EP);
                rd_reg(i, v); chk("R2 random readback", v, int'(cfgb[i]));
            end
        end

        // R7 overflow then later endpoint placed; exact fit
        for (int i = 0; i < NUM_EP; i++) cfgb[i] = 8'h00;
        cfgb[0] = 8'h80; cfgb[1] = 8'h88; cfgb[2] = 8'h81;
        full_pass("R7 skip");
        chk("R7 ep2 placed after skip", int'(ep_base[2*ADDR_W +: ADDR_W]), 4);
        for (int i = 0; i < NUM_EP; i++) cfgb[i] = 8'h00;
        cfgb[1] = 8'hA7; cfgb[2] = 8'h80;
        full_pass("R7 exact");
        chk("R7 exact fit active", int'(ep_active[1]), 1);

        // R10 invalidation rules on a mapped configuration
        for (int i = 0; i < NUM_EP; i++) cfgb[i] = 8'h81;
        cfgb[4] = 8'h02;
        full_pass("R10 base");
        cmd(8'h23, 16'h00D1);   // enabled ep3: only direction and type bits change
        @(negedge clk); chk("R10 dir/iso change harmless", int'(fifo_invalid), 0);
        cmd(8'h24, 16'h0005);   // disabled ep4 stays disabled
        @(negedge clk); chk("R10 disabled change harmless", int'(fifo_invalid), 0);
        cmd(8'h25, 16'h0083);   // enabled ep5 size change
        @(negedge clk); chk("R10 size change invalidates", int'(fifo_invalid), 1);
        cfgb[3] = 8'hD1; cfgb[4] = 8'h05; cfgb[5] = 8'h83;
        full_pass("R10 reclear");

        // R8 write during allocation is ignored
        write_all();
        repeat (3) @(negedge clk);
        cmd(8'h23, 16'h008F);
        wait_done(n);
        chk("R8 alloc still completes", int'(n >= 0), 1);
        rd_reg(3, v); chk("R8 busy write ignored", v, int'(cfgb[3]));

        // R9 bus reset after mapping
        pulse_bus_reset();
        chk("R9 active cleared", int'(ep_active), 0);
        chk("R9 len cleared", int'(|ep_len), 0);
        chk("R10 bus reset invalidates", int'(fifo_invalid), 1);
        rd_reg(5, v); chk("R9 enable cleared, rest kept", v, int'(cfgb[5] & 8'h7F));
        // R9 bus reset during allocation aborts it
        write_all();
        repeat (4) @(negedge clk);
        pulse_bus_reset();
        wait_done(n); chk("R9 aborted alloc no done", n, -1);
        chk("R9 aborted alloc inactive", int'(ep_active), 0);
        // R9 partial sequence before bus reset does not count
        for (int i = 0; i < 8; i++) cmd(8'h20 + 8'(i), {8'h00, cfgb[i]});
        pulse_bus_reset();
        for (int i = 8; i < NUM_EP; i++) cmd(8'h20 + 8'(i), {8'h00, cfgb[i]});
        wait_done(n); chk("R9 sequence restarted", n, -1);
        full_pass("R9 recover");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule